// File: doc/BRIEF.md
# Minute Watchdog Timer

A countdown watchdog sized in whole minutes and driven by four byte-wide registers. Software writes a timeout value, then arms the timer by writing a magic byte to a command register. A second magic byte disarms it. An external timebase strobe `tick_i` feeds a prescaler that makes one minute out of `TICKS_PER_MIN` strobes. Each minute decrements the count. When the count runs out, a sticky expiry bit is set and `timeout_o` pulses for one clock to the reset logic further down.

While the timer is armed, a new timer write is stored but does not reload the running count. Software refreshes the timer in three writes: disarm, write the timer, arm. A read of the timer register returns the whole minutes still left while armed, and the stored value while idle.

Top module: `minwdt_top`

## Requirements
- R1: After reset the enable flag (0xE1 bit 0) and the expiry flag (0xE2 bit 0) read 0, the timer register (0xE3) reads 1, and `timeout_o` is low.
- R2: Writing 0x55 to the command register (0xE0) arms the timer, and 0xE1 bit 0 then reads 1. Writing 0xAA to 0xE0 disarms it, and 0xE1 bit 0 then reads 0.
- R3: A write of any other byte to 0xE0 leaves the enable flag unchanged.
- R4: While disarmed, a byte written to 0xE3 reads back unchanged from 0xE3.
- R5: While armed, a write to 0xE3 does not change the running count, and a read of 0xE3 returns the minutes still left. The written value is loaded at the next arming, and 0xE3 reads it once the timer is idle.
- R6: While armed, the count drops by one on every `TICKS_PER_MIN`-th strobe of `tick_i`. Strobes received while disarmed are not counted, and a partial minute is discarded on disarm.
- R7: When the count goes from 1 to 0, `timeout_o` is high for exactly one cycle, 0xE2 bit 0 becomes 1, and 0xE1 bit 0 returns to 0.
- R8: The expiry flag stays set until the next arming command, which clears it.
- R9: Arming with a timer value of 0 never produces an expiry, and 0xE3 reads 0 while the timer is armed.
- R10: An arming command while the timer is already armed does not reload or restart the count.
- R11: Reads of the command register 0xE0 and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one per tick |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| timeout_o | output | 1 | One-cycle pulse on expiry |

## Verification
The bench builds the block with `TICKS_PER_MIN` = 4, so one minute lasts four strobes. With that setting the full 255-minute countdown finishes in about a thousand cycles, and the bench runs it to expiry. The small minute also makes it practical to place strobes at exact positions around a minute boundary: the bench checks that a partial minute is discarded on disarm, that a timer write does not reload a running count, and that the pulse lands on the exact strobe that ends the last minute.

// File: rtl/minwdt_pkg.sv
package minwdt_pkg;
  localparam logic [7:0] ADR_CMD    = 8'hE0;
  localparam logic [7:0] ADR_ENABLE = 8'hE1;
  localparam logic [7:0] ADR_STATUS = 8'hE2;
  localparam logic [7:0] ADR_TIMER  = 8'hE3;
  localparam logic [7:0] KEY_ARM    = 8'h55;
  localparam logic [7:0] KEY_DISARM = 8'hAA;
  localparam logic [7:0] TIMER_RST  = 8'd1;
endpackage

// File: rtl/minwdt_decode.sv
module minwdt_decode
  import minwdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              arm_o,
  output logic              disarm_o,
  output logic              timer_we_o
);
  logic cmd_hit;
  assign cmd_hit    = wr_i && (addr_i == ADDR_W'(ADR_CMD));
  assign arm_o      = cmd_hit && (wdata_i == DATA_W'(KEY_ARM));
  assign disarm_o   = cmd_hit && (wdata_i == DATA_W'(KEY_DISARM));
  assign timer_we_o = wr_i && (addr_i == ADDR_W'(ADR_TIMER));
endmodule

// File: rtl/minwdt_prescale.sv
module minwdt_prescale #(
  parameter int TICKS_PER_MIN = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic min_o
);
  localparam int PW = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MIN - 1);

  logic [PW-1:0] pcnt_q;
  logic          wrap;

  assign wrap  = (pcnt_q == LAST);
  assign min_o = run_i && tick_i && wrap;

  // partial minute is dropped whenever the timer is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pcnt_q <= '0;
    else if (!run_i)           pcnt_q <= '0;
    else if (tick_i && wrap)   pcnt_q <= '0;
    else if (tick_i)           pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/minwdt_count.sv
module minwdt_count #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         live;

  assign live     = (cnt_q != '0);
  assign expire_o = dec_i && (cnt_q == W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (dec_i && live)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/minwdt_top.sv
module minwdt_top
  import minwdt_pkg::*;
#(
  parameter int TICKS_PER_MIN = 6000,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              timeout_o
);
  logic              arm_cmd, disarm_cmd, timer_we;
  logic              arm_fire, min_tick, expire;
  logic              en_q, status_q, timeout_q;
  logic [DATA_W-1:0] timer_q, cnt_q;

  minwdt_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .arm_o     (arm_cmd),
    .disarm_o  (disarm_cmd),
    .timer_we_o(timer_we)
  );

  // arming while already armed is ignored
  assign arm_fire = arm_cmd && !en_q;

  minwdt_prescale #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_prescale (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (en_q),
    .tick_i(tick_i),
    .min_o (min_tick)
  );

  minwdt_count #(.W(DATA_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (arm_fire),
    .load_val_i(timer_q),
    .dec_i     (min_tick),
    .cnt_o     (cnt_q),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      status_q  <= 1'b0;
      timeout_q <= 1'b0;
      timer_q   <= DATA_W'(TIMER_RST);
    end else begin
      timeout_q <= expire;
      if (timer_we) timer_q <= wdata_i;
      if (expire || disarm_cmd) en_q <= 1'b0;
      else if (arm_fire)        en_q <= 1'b1;
      if (expire)        status_q <= 1'b1;
      else if (arm_fire) status_q <= 1'b0;
    end
  end

  assign timeout_o = timeout_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADR_ENABLE))      rdata_o[0] = en_q;
    else if (addr_i == ADDR_W'(ADR_STATUS)) rdata_o[0] = status_q;
    else if (addr_i == ADDR_W'(ADR_TIMER))  rdata_o = en_q ? cnt_q : timer_q;
  end
endmodule

// File: rtl/minwdt_chk.sv
module minwdt_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         timeout_o,
  input logic         en_q,
  input logic         status_q,
  input logic [W-1:0] cnt_q,
  input logic         min_tick,
  input logic         arm_fire
);
  assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  assert_expiry_effects_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (status_q && !en_q));

  assert_hold_between_minutes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !min_tick) |=> (cnt_q == $past(cnt_q)));

  assert_step_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && min_tick && cnt_q != '0) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

  assert_zero_unarmed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && cnt_q == '0) |=> !timeout_o);

  assert_status_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !arm_fire) |=> status_q);

  assert_status_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_fire |=> !status_q);
endmodule

bind minwdt_top minwdt_chk #(.W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .timeout_o(timeout_o),
  .en_q     (en_q),
  .status_q (status_q),
  .cnt_q    (cnt_q),
  .min_tick (min_tick),
  .arm_fire (arm_fire)
);

// File: tb/minwdt_top_bench.sv
module minwdt_top_bench;
  localparam int TPM = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       timeout_o;

  int checks = 0;
  int fails = 0;
  int tmo_seen = 0;

  minwdt_top #(.TICKS_PER_MIN(TPM)) u_minwdt_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .timeout_o(timeout_o)
  );

  always #5 clk_i = ~clk_i;

  always @(negedge clk_i) if (timeout_o) tmo_seen++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    addr_i = a;
    #1;
    v = int'(rdata_o);
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic t_reset;
    int v;
    rd(8'hE1, v); check("R1 enable", v, 0);
    rd(8'hE2, v); check("R1 status", v, 0);
    rd(8'hE3, v); check("R1 timer", v, 1);
    check("R1 timeout", int'(timeout_o), 0);
  endtask

  task automatic t_reads;
    int v;
    rd(8'hE0, v); check("R11 cmd read", v, 0);
    rd(8'h10, v); check("R11 unmapped", v, 0);
  endtask

  task automatic t_arm_disarm;
    int v;
    wr(8'hE0, 8'h12); rd(8'hE1, v); check("R3 bad key idle", v, 0);
    wr(8'hE3, 8'h2A); rd(8'hE3, v); check("R4 timer readback", v, 42);
    wr(8'hE3, 8'd3);
    wr(8'hE0, 8'h55); rd(8'hE1, v); check("R2 armed", v, 1);
    rd(8'hE3, v); check("R5 remaining", v, 3);
    wr(8'hE0, 8'h77); rd(8'hE1, v); check("R3 bad key armed", v, 1);
    wr(8'hE0, 8'hAA); rd(8'hE1, v); check("R2 disarmed", v, 0);
  endtask

  task automatic t_countdown;
    int v;
    int base;
    wr(8'hE0, 8'h55);
    ticks(TPM); rd(8'hE3, v); check("R6 one minute", v, 2);
    ticks(TPM - 1); repeat (5) @(negedge clk_i);
    rd(8'hE3, v); check("R6 partial minute", v, 2);
    ticks(1); rd(8'hE3, v); check("R6 minute boundary", v, 1);
    wr(8'hE3, 8'd9); rd(8'hE3, v); check("R5 no reload", v, 1);
    wr(8'hE0, 8'h55); rd(8'hE3, v); check("R10 rearm ignored", v, 1);
    base = tmo_seen;
    ticks(TPM - 1); check("R7 not yet", tmo_seen - base, 0);
    ticks(1); check("R7 pulse", int'(timeout_o), 1);
    rd(8'hE2, v); check("R7 status set", v, 1);
    rd(8'hE1, v); check("R7 enable drop", v, 0);
    @(negedge clk_i); check("R7 single cycle", int'(timeout_o), 0);
    repeat (6) @(negedge clk_i);
    rd(8'hE2, v); check("R8 sticky", v, 1);
    rd(8'hE3, v); check("R5 stored value", v, 9);
    wr(8'hE0, 8'h55);
    rd(8'hE2, v); check("R8 cleared by arm", v, 0);
    rd(8'hE3, v); check("R5 loaded on arm", v, 9);
    wr(8'hE0, 8'hAA);
  endtask

  task automatic t_partial_drop;
    int v;
    wr(8'hE3, 8'd2);
    wr(8'hE0, 8'h55);
    ticks(TPM - 1);
    wr(8'hE0, 8'hAA);
    ticks(3);
    wr(8'hE0, 8'h55);
    rd(8'hE3, v); check("R6 reload after disarm", v, 2);
    ticks(TPM - 1); rd(8'hE3, v); check("R6 partial dropped", v, 2);
    ticks(1); rd(8'hE3, v); check("R6 new minute", v, 1);
    wr(8'hE0, 8'hAA);
  endtask

  task automatic t_zero;
    int v;
    int base;
    wr(8'hE3, 8'd0);
    wr(8'hE0, 8'h55);
    base = tmo_seen;
    ticks(TPM * 10);
    repeat (2) @(negedge clk_i);
    check("R9 no pulse", tmo_seen - base, 0);
    rd(8'hE2, v); check("R9 no status", v, 0);
    rd(8'hE1, v); check("R9 still armed", v, 1);
    rd(8'hE3, v); check("R9 reads zero", v, 0);
    wr(8'hE0, 8'hAA);
  endtask

  task automatic t_full_range;
    int v;
    int base;
    wr(8'hE3, 8'd255);
    wr(8'hE0, 8'h55);
    base = tmo_seen;
    ticks(255 * TPM - 1);
    rd(8'hE3, v); check("R6 last minute", v, 1);
    check("R7 none early", tmo_seen - base, 0);
    ticks(1); check("R7 pulse at 255", int'(timeout_o), 1);
    rd(8'hE2, v); check("R7 status at 255", v, 1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_reads();
    t_arm_disarm();
    t_countdown();
    t_partial_drop();
    t_zero();
    t_full_range();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule